// File: doc/BRIEF.md
# Consumer-Electronics-Control Frame Transmitter

This block sends one frame at a time onto a single-wire, open-drain control bus shared by the devices of a home-entertainment link. A host places up to sixteen message bytes into a flat transmit data vector made of 32-bit words, sets a length field and raises a start bit. The block then produces a long start pulse followed by every byte, most significant bit first. Each byte is followed by an end-of-message flag bit and an acknowledge slot. All pulse widths are counted in ticks of a programmable prescaler, so one design serves any system clock.

In the acknowledge slot the transmitter only drives a short low pulse and then lets go of the line. It samples the line part way through the slot. A line still held low by the addressed follower counts as an acknowledge. A negative acknowledge on the first attempt restarts the whole frame once. After the frame ends, a one-cycle completion interrupt fires and a status flag tells whether the frame was accepted. A soft-reset input parks the transmitter and releases the line.

The controller has five states. `ST_IDLE` waits for a start edge. `ST_START` sends the start pulse. `ST_DATA` walks the eight data bits. `ST_EOM` sends the end-of-message flag. `ST_ACK` runs the acknowledge slot. The transitions are:

- launch: `ST_IDLE` to `ST_START`.
- start done: `ST_START` to `ST_DATA`.
- next bit: `ST_DATA` to `ST_DATA`.
- byte sent: `ST_DATA` to `ST_EOM`.
- flag sent: `ST_EOM` to `ST_ACK`.
- next byte: `ST_ACK` to `ST_DATA`.
- retry: `ST_ACK` to `ST_START`.
- finish: `ST_ACK` to `ST_IDLE`, after success or after a second refusal.
- abort: any state to `ST_IDLE` while soft reset is high.

Top module: `cec_frame_tx`

## Requirements
- R1: After reset the line is released (`cec_drive_low`=0), and `tx_busy`, `tx_good` and `tx_done_irq` are all 0.
- R2: A frame starts only on a 0-to-1 change of `tx_start` seen while idle. Holding `tx_start` at 1 after a frame starts nothing new. Toggling it during a frame has no effect.
- R3: The start pulse drives the line low for `t_start_low` ticks. The start symbol lasts `t_start_period` ticks, and one system clock separates it from the next symbol.
- R4: Data bits go out most significant bit first. A 0 is low for `t_zero_low` ticks and a 1 is low for `t_one_low` ticks. Each bit lasts `t_bit_period` ticks plus one clock.
- R5: Byte k of the frame is `tx_data[8k+7:8k]`, so byte 0 sits in bits 7:0 of word 0. The frame carries `tx_len_m1`+1 bytes.
- R6: The end-of-message bit after each byte is 1 only for the final byte and 0 for every other byte.
- R7: In the acknowledge slot the block drives a `t_one_low` low pulse and then releases the line. It samples the synchronised line at tick `t_ack_sample`. A low sample is an acknowledge.
- R8: A refused byte on the first attempt restarts the frame from the start pulse exactly once. A refusal on the second attempt ends the frame, so at most two attempts are made.
- R9: At the end of a frame `tx_done_irq` pulses for one clock while `tx_busy` falls. `tx_good` then reads 1 if every byte was acknowledged and 0 after two refused attempts. `tx_good` is cleared at launch.
- R10: While `tx_soft_reset` is 1, from the next clock on, the block is idle, the line is released and start edges are ignored. A frame in progress is dropped with no interrupt.
- R11: One tick occurs every `div_cnt` system clocks. A value of 0 or 1 gives a tick on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_cnt | input | DIV_W (12) | Clocks per timing tick |
| t_start_low | input | TICK_W (8) | Start pulse low time in ticks |
| t_start_period | input | TICK_W (8) | Start symbol length in ticks |
| t_zero_low | input | TICK_W (8) | Low time of a 0 bit in ticks |
| t_one_low | input | TICK_W (8) | Low time of a 1 bit and of the acknowledge pulse |
| t_bit_period | input | TICK_W (8) | Bit symbol length in ticks |
| t_ack_sample | input | TICK_W (8) | Tick at which the acknowledge slot is sampled |
| tx_data | input | NUM_WORDS*32 (128) | Message bytes, byte 0 in bits 7:0 |
| tx_len_m1 | input | log2(NUM_WORDS*4) (4) | Number of bytes minus one |
| tx_start | input | 1 | Launch request, acted on at its rising edge |
| tx_soft_reset | input | 1 | Holds the transmitter idle |
| cec_line_in | input | 1 | Sensed bus level (1 = high) |
| cec_drive_low | output | 1 | 1 pulls the open-drain line low |
| tx_busy | output | 1 | Frame in progress |
| tx_good | output | 1 | Last frame was acknowledged |
| tx_done_irq | output | 1 | One-clock completion pulse |

## Verification
The hardest condition to reach is a refusal that comes part way through the first attempt and is followed by acceptance on the second. Reaching it needs a follower that decides per byte and per attempt whether to hold the line low in the acknowledge slot. The bench builds that follower from the block's own drive output. It times each low pulse to decode start pulses, data bits, flags and slots. It then stretches the slot low for the bytes it chooses to accept, so a refusal can be placed on any byte of either attempt. The same decoder rebuilds the byte stream of both attempts, which confirms that the retry restarts from byte 0.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_EOM,
        ST_ACK
    } tx_state_e;
endpackage

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_cnt,
    output logic             tick
);
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W:0]   pnext;

    assign pnext = {1'b0, pcnt} + (DIV_W + 1)'(1);
    assign tick  = !clr && (pnext >= {1'b0, div_cnt});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clr || tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + DIV_W'(1);
    end
endmodule

// File: rtl/cec_symbol_timer.sv
module cec_symbol_timer #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              load,
    input  logic [TICK_W-1:0] low_len,
    input  logic [TICK_W-1:0] period,
    input  logic [TICK_W-1:0] sample_at,
    input  logic              line_in,
    output logic              drive_low,
    output logic              done,
    output logic              line_sample
);
    localparam logic [TICK_W-1:0] T_ONE = TICK_W'(1);

    logic              active;
    logic [TICK_W-1:0] cnt;

    assign done      = active && tick && (cnt == period - T_ONE);
    assign drive_low = active && (cnt < low_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active      <= 1'b0;
            cnt         <= '0;
            line_sample <= 1'b1;
        end else if (clr) begin
            active      <= 1'b0;
            cnt         <= '0;
            line_sample <= 1'b1;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick) begin
            if (cnt == sample_at)
                line_sample <= line_in;
            if (done)
                active <= 1'b0;
            else
                cnt <= cnt + T_ONE;
        end
    end
endmodule

// File: rtl/cec_frame_tx.sv
module cec_frame_tx
    import cec_tx_pkg::*;
#(
    parameter int DIV_W     = 12,
    parameter int TICK_W    = 8,
    parameter int NUM_WORDS = 4,
    localparam int NUM_BYTES = NUM_WORDS * 4,
    localparam int LEN_W     = $clog2(NUM_BYTES),
    localparam int DATA_W    = NUM_WORDS * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_cnt,
    input  logic [TICK_W-1:0] t_start_low,
    input  logic [TICK_W-1:0] t_start_period,
    input  logic [TICK_W-1:0] t_zero_low,
    input  logic [TICK_W-1:0] t_one_low,
    input  logic [TICK_W-1:0] t_bit_period,
    input  logic [TICK_W-1:0] t_ack_sample,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [LEN_W-1:0]  tx_len_m1,
    input  logic              tx_start,
    input  logic              tx_soft_reset,
    input  logic              cec_line_in,
    output logic              cec_drive_low,
    output logic              tx_busy,
    output logic              tx_good,
    output logic              tx_done_irq
);
    tx_state_e         state;
    logic [LEN_W-1:0]  byte_idx;
    logic [2:0]        bit_idx;
    logic              attempt;
    logic              armed;
    logic              start_q;
    logic [1:0]        line_sync;

    logic              tick;
    logic              sym_done;
    logic              line_sample;
    logic [TICK_W-1:0] sym_low;
    logic [TICK_W-1:0] sym_period;
    logic [7:0]        cur_byte;
    logic              last_byte;
    logic              start_rise;
    logic              acked;

    assign cur_byte   = tx_data[{byte_idx, 3'b000} +: 8];
    assign last_byte  = (byte_idx == tx_len_m1);
    assign start_rise = tx_start && !start_q;
    assign acked      = !line_sample;
    assign tx_busy    = (state != ST_IDLE);

    cec_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tx_soft_reset),
        .div_cnt (div_cnt),
        .tick    (tick)
    );

    cec_symbol_timer #(.TICK_W(TICK_W)) u_sym (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (tx_soft_reset),
        .tick        (tick),
        .load        (armed),
        .low_len     (sym_low),
        .period      (sym_period),
        .sample_at   (t_ack_sample),
        .line_in     (line_sync[1]),
        .drive_low   (cec_drive_low),
        .done        (sym_done),
        .line_sample (line_sample)
    );

    // Symbol shape chosen by the current state
    always_comb begin
        sym_low    = t_one_low;
        sym_period = t_bit_period;
        unique case (state)
            ST_IDLE: begin
                sym_low    = t_one_low;
                sym_period = t_bit_period;
            end
            ST_START: begin
                sym_low    = t_start_low;
                sym_period = t_start_period;
            end
            ST_DATA:  sym_low = cur_byte[bit_idx] ? t_one_low : t_zero_low;
            ST_EOM:   sym_low = last_byte ? t_one_low : t_zero_low;
            ST_ACK:   sym_low = t_one_low;
        endcase
    end

    // State register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            byte_idx    <= '0;
            bit_idx     <= 3'd7;
            attempt     <= 1'b0;
            armed       <= 1'b0;
            start_q     <= 1'b0;
            line_sync   <= 2'b11;
            tx_good     <= 1'b0;
            tx_done_irq <= 1'b0;
        end else begin
            start_q     <= tx_start;
            line_sync   <= {line_sync[0], cec_line_in};
            armed       <= 1'b0;
            tx_done_irq <= 1'b0;
            if (tx_soft_reset) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: if (start_rise) begin
                        state    <= ST_START;
                        attempt  <= 1'b0;
                        byte_idx <= '0;
                        tx_good  <= 1'b0;
                        armed    <= 1'b1;
                    end
                    ST_START: if (sym_done) begin
                        state   <= ST_DATA;
                        bit_idx <= 3'd7;
                        armed   <= 1'b1;
                    end
                    ST_DATA: if (sym_done) begin
                        armed <= 1'b1;
                        if (bit_idx == 3'd0)
                            state <= ST_EOM;
                        else
                            bit_idx <= bit_idx - 3'd1;
                    end
                    ST_EOM: if (sym_done) begin
                        state <= ST_ACK;
                        armed <= 1'b1;
                    end
                    ST_ACK: if (sym_done) begin
                        if (acked) begin
                            if (last_byte) begin
                                state       <= ST_IDLE;
                                tx_good     <= 1'b1;
                                tx_done_irq <= 1'b1;
                            end else begin
                                state    <= ST_DATA;
                                byte_idx <= byte_idx + LEN_W'(1);
                                bit_idx  <= 3'd7;
                                armed    <= 1'b1;
                            end
                        end else if (!attempt) begin
                            state    <= ST_START;
                            attempt  <= 1'b1;
                            byte_idx <= '0;
                            armed    <= 1'b1;
                        end else begin
                            state       <= ST_IDLE;
                            tx_done_irq <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/cec_frame_tx_chk.sv
module cec_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_start,
    input logic tx_soft_reset,
    input logic cec_drive_low,
    input logic tx_busy,
    input logic tx_good,
    input logic tx_done_irq
);
    // R10
    soft_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soft_reset |=> (!tx_busy && !cec_drive_low));

    // R1
    drive_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cec_drive_low |-> tx_busy);

    // R2
    launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> ($past(tx_start) && !$past(tx_soft_reset)));

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_irq |=> !tx_done_irq);

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_irq |-> !tx_busy);

    // R9
    good_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_good) |-> tx_done_irq);
endmodule

bind cec_frame_tx cec_frame_tx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_start      (tx_start),
    .tx_soft_reset (tx_soft_reset),
    .cec_drive_low (cec_drive_low),
    .tx_busy       (tx_busy),
    .tx_good       (tx_good),
    .tx_done_irq   (tx_done_irq)
);

// File: tb/tb_cec_frame_tx.sv
module tb_cec_frame_tx;
    localparam int CLK_PERIOD = 10;
    localparam int T_SL = 148, T_SP = 180, T_ZL = 60, T_OL = 24, T_BP = 96, T_AS = 42;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  div_cnt = 12'd1;
    logic [127:0] tx_data = '0;
    logic [3:0]   tx_len_m1 = '0;
    logic         tx_start = 1'b0;
    logic         tx_soft_reset = 1'b0;
    logic         cec_line_in;
    logic         cec_drive_low, tx_busy, tx_good, tx_done_irq;

    int checks = 0, fails = 0;

    // follower policy and monitor state
    logic ack_a0 = 1'b1, ack_a1 = 1'b1;
    int   nack_byte = 0;
    int   scale = 1;
    logic mon_clr = 1'b0;
    logic fol_low;
    int   fol_cnt, lowcnt, nbits, starts, rx_cnt, len_err, per_err, irq_cnt;
    int   last_start_low, period_cnt, last_kind;
    logic prev_drv;
    logic [7:0] shift_b;
    logic       eom_b;
    logic [7:0] rx_bytes [0:63];
    logic       rx_eom   [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fol_low     = (fol_cnt != 0);
    assign cec_line_in = !(cec_drive_low || fol_low);

    cec_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .div_cnt(div_cnt),
        .t_start_low(8'(T_SL)), .t_start_period(8'(T_SP)),
        .t_zero_low(8'(T_ZL)), .t_one_low(8'(T_OL)),
        .t_bit_period(8'(T_BP)), .t_ack_sample(8'(T_AS)),
        .tx_data(tx_data), .tx_len_m1(tx_len_m1),
        .tx_start(tx_start), .tx_soft_reset(tx_soft_reset),
        .cec_line_in(cec_line_in), .cec_drive_low(cec_drive_low),
        .tx_busy(tx_busy), .tx_good(tx_good), .tx_done_irq(tx_done_irq)
    );

    // Bus decoder and acknowledging follower
    initial begin
        fol_cnt = 0; lowcnt = 0; nbits = 0; starts = 0; rx_cnt = 0; len_err = 0;
        per_err = 0; irq_cnt = 0; last_start_low = 0; period_cnt = 0; last_kind = 0;
        prev_drv = 1'b0; shift_b = '0; eom_b = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_clr) begin
                fol_cnt = 0; lowcnt = 0; nbits = 0; starts = 0; rx_cnt = 0; len_err = 0;
                per_err = 0; irq_cnt = 0; last_start_low = 0; period_cnt = 0; last_kind = 0;
            end else begin
                if (fol_cnt > 0) fol_cnt = fol_cnt - 1;
                if (tx_done_irq) irq_cnt = irq_cnt + 1;
                period_cnt = period_cnt + 1;
                if (cec_drive_low && !prev_drv) begin
                    if (scale == 1 && last_kind == 1 && period_cnt != T_SP + 1) per_err = per_err + 1;
                    if (scale == 1 && last_kind == 2 && period_cnt != T_BP + 1) per_err = per_err + 1;
                    period_cnt = 0;
                    if (nbits % 10 == 9 && starts > 0) begin
                        if (((starts == 1) ? ack_a0 : ack_a1) || (nbits / 10) < nack_byte)
                            fol_cnt = T_ZL * scale;
                    end
                end
                if (cec_drive_low) lowcnt = lowcnt + 1;
                if (!cec_drive_low && prev_drv) begin
                    if (lowcnt >= 100 * scale) begin
                        starts = starts + 1; nbits = 0; last_kind = 1;
                        last_start_low = lowcnt;
                        if (scale == 1 && lowcnt != T_SL) len_err = len_err + 1;
                    end else begin
                        last_kind = 2;
                        if (scale == 1 && lowcnt != T_ZL && lowcnt != T_OL) len_err = len_err + 1;
                        if (nbits % 10 < 8) shift_b = {shift_b[6:0], (lowcnt < 42 * scale)};
                        else if (nbits % 10 == 8) eom_b = (lowcnt < 42 * scale);
                        else if (rx_cnt < 64) begin
                            rx_bytes[rx_cnt] = shift_b; rx_eom[rx_cnt] = eom_b;
                            rx_cnt = rx_cnt + 1;
                        end
                        nbits = nbits + 1;
                    end
                    lowcnt = 0;
                end
                prev_drv = cec_drive_low;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
    endtask

    task automatic wait_irq();
        int guard = 0;
        while (irq_cnt == 0 && guard < 60000) begin
            @(negedge clk); guard++;
        end
        @(negedge clk);
    endtask

    task automatic launch();
        @(negedge clk) tx_start = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 drive", int'(cec_drive_low), 0);
        chk("R1 busy", int'(tx_busy), 0);
        chk("R1 good", int'(tx_good), 0);
        chk("R1 irq", int'(tx_done_irq), 0);
    endtask

    task automatic t_two_bytes();
        clear_mon();
        tx_data = '0; tx_data[15:0] = 16'h364F; tx_len_m1 = 4'd1;
        ack_a0 = 1'b1; ack_a1 = 1'b1; nack_byte = 0;
        launch(); wait_irq(); tx_start = 1'b0;
        chk("R8 single attempt", starts, 1);
        chk("R5 byte count", rx_cnt, 2);
        chk("R4 byte0 msb first", int'(rx_bytes[0]), 'h4F);
        chk("R5 byte1", int'(rx_bytes[1]), 'h36);
        chk("R6 eom byte0", int'(rx_eom[0]), 0);
        chk("R6 eom byte1", int'(rx_eom[1]), 1);
        chk("R3 start low", last_start_low, T_SL);
        chk("R4 bit low lengths", len_err, 0);
        chk("R3 symbol periods", per_err, 0);
        chk("R9 tx_good", int'(tx_good), 1);
        chk("R9 irq count", irq_cnt, 1);
        chk("R9 busy cleared", int'(tx_busy), 0);
    endtask

    task automatic t_full_buffer();
        int bad = 0, bad_eom = 0;
        clear_mon();
        for (int k = 0; k < 16; k++) tx_data[8*k +: 8] = 8'(k * 29 + 7);
        tx_len_m1 = 4'd15;
        launch(); wait_irq(); tx_start = 1'b0;
        chk("R5 sixteen bytes", rx_cnt, 16);
        for (int k = 0; k < 16; k++) begin
            if (rx_bytes[k] != 8'(k * 29 + 7)) bad++;
            if (int'(rx_eom[k]) != ((k == 15) ? 1 : 0)) bad_eom++;
        end
        chk("R5 byte order over words", bad, 0);
        chk("R6 eom only last", bad_eom, 0);
        chk("R9 good full", int'(tx_good), 1);
    endtask

    task automatic t_retry_ok();
        clear_mon();
        tx_data = '0; tx_data[23:0] = 24'hA1C3E5; tx_len_m1 = 4'd2;
        ack_a0 = 1'b0; ack_a1 = 1'b1; nack_byte = 1;
        launch(); wait_irq(); tx_start = 1'b0;
        chk("R8 two attempts", starts, 2);
        chk("R8 bytes over attempts", rx_cnt, 5);
        chk("R8 retry restarts byte0", int'(rx_bytes[2]), 'hE5);
        chk("R8 final byte", int'(rx_bytes[4]), 'hA1);
        chk("R7 R9 good after retry", int'(tx_good), 1);
        chk("R9 one irq", irq_cnt, 1);
    endtask

    task automatic t_double_nack();
        clear_mon();
        tx_data = '0; tx_data[15:0] = 16'h1234; tx_len_m1 = 4'd1;
        ack_a0 = 1'b0; ack_a1 = 1'b0; nack_byte = 0;
        launch(); wait_irq(); tx_start = 1'b0;
        chk("R8 stops after two", starts, 2);
        chk("R7 nack ends each attempt", rx_cnt, 2);
        chk("R9 good low on nack", int'(tx_good), 0);
        chk("R9 irq on nack", irq_cnt, 1);
        ack_a0 = 1'b1; ack_a1 = 1'b1;
    endtask

    task automatic t_start_edge();
        clear_mon();
        tx_data = '0; tx_data[7:0] = 8'h5A; tx_len_m1 = 4'd0;
        launch(); wait_irq();
        repeat (500) @(negedge clk);
        chk("R2 level start no relaunch", int'(tx_busy), 0);
        chk("R2 one start pulse", starts, 1);
        tx_start = 1'b0;
        clear_mon();
        launch();
        repeat (400) @(negedge clk);
        tx_start = 1'b0;
        repeat (3) @(negedge clk);
        tx_start = 1'b1;
        wait_irq(); tx_start = 1'b0;
        chk("R2 toggle mid-frame ignored", starts, 1);
        chk("R2 single irq", irq_cnt, 1);
    endtask

    task automatic t_soft_reset();
        clear_mon();
        tx_data = '0; tx_data[31:0] = 32'hDEADBEEF; tx_len_m1 = 4'd3;
        launch();
        repeat (700) @(negedge clk);
        tx_soft_reset = 1'b1;
        @(negedge clk);
        chk("R10 line released", int'(cec_drive_low), 0);
        chk("R10 idle", int'(tx_busy), 0);
        tx_start = 1'b0;
        repeat (3) @(negedge clk);
        tx_start = 1'b1;
        repeat (300) @(negedge clk);
        chk("R10 start ignored", int'(tx_busy), 0);
        chk("R10 no irq on abort", irq_cnt, 0);
        tx_soft_reset = 1'b0;
        repeat (300) @(negedge clk);
        chk("R10 R2 held start after release", int'(tx_busy), 0);
        tx_start = 1'b0;
        clear_mon();
        launch(); wait_irq(); tx_start = 1'b0;
        chk("R10 recovers", int'(tx_good), 1);
        chk("R10 recovered bytes", rx_cnt, 4);
    endtask

    task automatic t_prescaler();
        clear_mon();
        scale = 3; div_cnt = 12'd3;
        tx_data = '0; tx_data[7:0] = 8'hC6; tx_len_m1 = 4'd0;
        launch(); wait_irq(); tx_start = 1'b0;
        chk("R11 start low lower", int'(last_start_low >= 3 * (T_SL - 1) + 1), 1);
        chk("R11 start low upper", int'(last_start_low <= 3 * T_SL), 1);
        chk("R11 byte", int'(rx_bytes[0]), 'hC6);
        chk("R11 good", int'(tx_good), 1);
        scale = 1; div_cnt = 12'd1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_two_bytes();
        t_full_buffer();
        t_retry_ok();
        t_double_nack();
        t_start_edge();
        t_soft_reset();
        t_prescaler();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule